// File: doc/BRIEF.md
# Snooping MESI Line Controller

This block keeps the four-state coherence record (Invalid, Shared, Exclusive, Modified) for every line of one private cache on a snooping shared bus. Each cycle it can take one local request from the processor side (read, write or eviction of a line), one command snooped from another cache on the bus, and one fill response for an outstanding miss. Each line is named by a small index into the state array. From these inputs it updates the line states and produces bus requests, a dirty-data supply request and a writeback request. Tag matching, data storage and bus arbitration belong to the surrounding cache.

A local read or write that misses issues a bus read or a read-for-ownership and then waits for the fill. The fill carries a shared-line indication that decides between Exclusive and Shared for a read. While that one miss is outstanding, new local requests are held off. A write to a Shared line broadcasts an upgrade and takes ownership in the same cycle. A write to an Exclusive line takes ownership silently. When a snoop and a local request name the same line in one cycle, the snoop is applied first and the local request is then decided against the line's new state. A combinational lookup port lets the tag pipeline read any line's state.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Reset (synchronous, active high) puts every line in Invalid (state code I=0, S=1, E=2, M=3) and leaves the controller ready for local requests.
- R2: A local read (op code 0) to an Invalid line drives bus command 1 (read) with the line index and leaves the line Invalid. The fill then sets the line to Shared when the shared indication is 1 and to Exclusive when it is 0, and raises the done output in the fill cycle.
- R3: A local write (op code 1) to an Invalid line drives bus command 2 (read-for-ownership), and the fill sets the line to Modified whatever the shared indication says.
- R4: A local write to a Shared line drives bus command 3 (upgrade), raises done in the same cycle and leaves the line Modified.
- R5: A local write to an Exclusive line moves it to Modified with bus command 0 (none) and done raised.
- R6: A local read that finds the line in S, E or M, and a write that finds it in M, raise done in the same cycle, drive no bus command and leave the state unchanged.
- R7: A snooped bus read (snoop code 1) moves M to S with a supply request for that index, and moves E to S without one. S and I are left as they are.
- R8: A snooped read-for-ownership (code 2) or upgrade (code 3) moves S, E or M to I. A supply request is raised only when the line was M.
- R9: An eviction (op code 2) of an M line raises the writeback request with its index and leaves it I. An eviction of S or E leaves the line I with no writeback. All evictions raise done.
- R10: When a snoop and a local request name the same line in one cycle, the snoop's transition is applied first and the local request is decided against the resulting state.
- R11: While a miss is outstanding, the ready output is low, and a local request presented then changes no line, issues no bus command and raises no done. Ready returns in the cycle after the fill.
- R12: Op code 3 is a no-operation: it changes no line and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_valid | input | 1 | Local request present |
| lcl_op | input | 2 | Local operation: 0 read, 1 write, 2 evict, 3 no-op |
| lcl_idx | input | IDX_W | Line index of the local request |
| lcl_ready | output | 1 | High when no miss is outstanding |
| lcl_done | output | 1 | Local request or fill completes this cycle |
| snp_cmd | input | 2 | Snooped command: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| snp_idx | input | IDX_W | Line index of the snooped command |
| fill_valid | input | 1 | Fill for the outstanding miss arrives |
| fill_shared | input | 1 | Another cache holds the filled line |
| bus_cmd | output | 2 | Bus request: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| bus_idx | output | IDX_W | Line index of the bus request |
| supply_valid | output | 1 | Supply dirty data for a snooped line |
| supply_idx | output | IDX_W | Line index to supply |
| wb_valid | output | 1 | Write back an evicted dirty line |
| wb_idx | output | IDX_W | Line index to write back |
| look_idx | input | IDX_W | Line index for the state lookup |
| look_state | output | 2 | State of the looked-up line |

## Verification
The bench goes after four kinds of failure. The first is the fill choice between E and S: a design that ignored the shared indication would hand out exclusive copies of lines other caches still hold. The second is the silent E-to-M step: a design that sent an upgrade there would waste bus cycles, and one that stayed in E would lose the dirty status, so a later snoop would supply no data and an eviction would skip the writeback. The bench sweeps every start state against every snoop and every local op. It also runs each pairing of a snoop with a read or write to the same line in one cycle, where deciding the local request on the stale state would issue the wrong bus command or leave the line out of step with the other caches. Finally it presents requests while a miss is outstanding, which a design without the hold-off would act on by corrupting other lines or issuing a second miss.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_UPGR = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } lcl_op_t;

    typedef struct packed {
        mesi_t nxt;
        logic  upd;
        logic  supply;
    } snp_res_t;

    typedef struct packed {
        mesi_t    nxt;
        logic     upd;
        bus_cmd_t bus;
        logic     done;
        logic     miss;
        logic     wb;
    } lcl_res_t;

    // Reaction of one line to a command observed on the bus.
    function automatic snp_res_t snoop_react(mesi_t cur, bus_cmd_t cmd);
        snp_res_t r;
        r.nxt    = cur;
        r.upd    = 1'b0;
        r.supply = 1'b0;
        unique case (cmd)
            BUS_RD: begin
                if (cur == ST_M || cur == ST_E) begin
                    r.nxt    = ST_S;
                    r.upd    = 1'b1;
                    r.supply = (cur == ST_M);
                end
            end
            BUS_RDX, BUS_UPGR: begin
                if (cur != ST_I) begin
                    r.nxt    = ST_I;
                    r.upd    = 1'b1;
                    r.supply = (cur == ST_M);
                end
            end
            default: ;
        endcase
        return r;
    endfunction

    // Decision for a local request given the line's (post-snoop) state.
    function automatic lcl_res_t local_react(mesi_t cur, lcl_op_t op);
        lcl_res_t r;
        r.nxt  = cur;
        r.upd  = 1'b0;
        r.bus  = BUS_NONE;
        r.done = 1'b0;
        r.miss = 1'b0;
        r.wb   = 1'b0;
        unique case (op)
            OP_READ: begin
                if (cur == ST_I) begin
                    r.bus  = BUS_RD;
                    r.miss = 1'b1;
                end else begin
                    r.done = 1'b1;
                end
            end
            OP_WRITE: begin
                if (cur == ST_I) begin
                    r.bus  = BUS_RDX;
                    r.miss = 1'b1;
                end else begin
                    r.done = 1'b1;
                    r.nxt  = ST_M;
                    r.upd  = (cur != ST_M);
                    if (cur == ST_S) r.bus = BUS_UPGR;
                end
            end
            OP_EVICT: begin
                r.done = 1'b1;
                r.nxt  = ST_I;
                r.upd  = (cur != ST_I);
                r.wb   = (cur == ST_M);
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic mesi_t fill_state(logic was_write, logic shared);
        if (was_write) return ST_M;
        return shared ? ST_S : ST_E;
    endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    // port A: snoop updates (lower priority)
    input  logic             a_we,
    input  logic [IDX_W-1:0] a_idx,
    input  mesi_t            a_st,
    // port B: local or fill updates (higher priority, already post-snoop)
    input  logic             b_we,
    input  logic [IDX_W-1:0] b_idx,
    input  mesi_t            b_st,
    input  logic [IDX_W-1:0] r0_idx,
    output mesi_t            r0_st,
    input  logic [IDX_W-1:0] r1_idx,
    output mesi_t            r1_st,
    input  logic [IDX_W-1:0] r2_idx,
    output mesi_t            r2_st
);

    mesi_t line_st [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                line_st[g] <= ST_I;
            end else if (b_we && b_idx == IDX_W'(g)) begin
                line_st[g] <= b_st;
            end else if (a_we && a_idx == IDX_W'(g)) begin
                line_st[g] <= a_st;
            end
        end
    end

    assign r0_st = line_st[r0_idx];
    assign r1_st = line_st[r1_idx];
    assign r2_st = line_st[r2_idx];

    // R10: a same-cycle local write replaces the snoop's write to that line
    a_r10_local_after_snoop: assert property (@(posedge clk) disable iff (rst)
        (a_we && b_we && a_idx == b_idx) |=> (line_st[$past(b_idx)] == $past(b_st)));

endmodule

// File: rtl/mesi_miss_tracker.sv
module mesi_miss_tracker
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             start_write,
    input  logic             fill_valid,
    input  logic             fill_shared,
    output logic             busy,
    output logic             fill_we,
    output logic [IDX_W-1:0] fill_idx,
    output mesi_t            fill_st
);

    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             pend_wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            pend_wr_q  <= 1'b0;
        end else if (start) begin
            pend_q     <= 1'b1;
            pend_idx_q <= start_idx;
            pend_wr_q  <= start_write;
        end else if (fill_we) begin
            pend_q <= 1'b0;
        end
    end

    assign busy     = pend_q;
    assign fill_we  = pend_q && fill_valid;
    assign fill_idx = pend_idx_q;
    assign fill_st  = fill_state(pend_wr_q, fill_shared);

    // R11: only one miss at a time
    a_r11_single_miss: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

    // R11: a fill ends the wait in the next cycle
    a_r11_fill_releases: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> !busy);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lcl_valid,
    input  logic [1:0]       lcl_op,
    input  logic [IDX_W-1:0] lcl_idx,
    output logic             lcl_ready,
    output logic             lcl_done,
    input  logic [1:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             fill_valid,
    input  logic             fill_shared,
    output logic [1:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    output logic             supply_valid,
    output logic [IDX_W-1:0] supply_idx,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    input  logic [IDX_W-1:0] look_idx,
    output logic [1:0]       look_state
);

    bus_cmd_t snp_c;
    lcl_op_t  op_c;
    mesi_t    snp_cur, lcl_raw, lcl_cur, look_st;
    snp_res_t snp_r;
    lcl_res_t lr;
    logic     same_line, accept, busy;
    logic     fill_we;
    logic [IDX_W-1:0] fill_idx;
    mesi_t    fill_st;
    logic     b_we;
    logic [IDX_W-1:0] b_idx;
    mesi_t    b_st;

    assign snp_c = bus_cmd_t'(snp_cmd);
    assign op_c  = lcl_op_t'(lcl_op);

    mesi_state_array #(.LINES(LINES)) u_array (
        .clk    (clk),
        .rst    (rst),
        .a_we   (snp_r.upd),
        .a_idx  (snp_idx),
        .a_st   (snp_r.nxt),
        .b_we   (b_we),
        .b_idx  (b_idx),
        .b_st   (b_st),
        .r0_idx (snp_idx),
        .r0_st  (snp_cur),
        .r1_idx (lcl_idx),
        .r1_st  (lcl_raw),
        .r2_idx (look_idx),
        .r2_st  (look_st)
    );

    // Snoop first; the local request then sees the post-snoop state.
    assign snp_r     = snoop_react(snp_cur, snp_c);
    assign same_line = (snp_c != BUS_NONE) && (snp_idx == lcl_idx);
    assign lcl_cur   = same_line ? snp_r.nxt : lcl_raw;
    assign accept    = lcl_valid && !busy;
    assign lr        = local_react(lcl_cur, op_c);

    mesi_miss_tracker #(.IDX_W(IDX_W)) u_miss (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && lr.miss),
        .start_idx   (lcl_idx),
        .start_write (op_c == OP_WRITE),
        .fill_valid  (fill_valid),
        .fill_shared (fill_shared),
        .busy        (busy),
        .fill_we     (fill_we),
        .fill_idx    (fill_idx),
        .fill_st     (fill_st)
    );

    always_comb begin
        b_we  = 1'b0;
        b_idx = lcl_idx;
        b_st  = lr.nxt;
        if (fill_we) begin
            b_we  = 1'b1;
            b_idx = fill_idx;
            b_st  = fill_st;
        end else if (accept && lr.upd) begin
            b_we = 1'b1;
        end
    end

    assign lcl_ready    = !busy;
    assign lcl_done     = (accept && lr.done) || fill_we;
    assign bus_cmd      = accept ? lr.bus : BUS_NONE;
    assign bus_idx      = lcl_idx;
    assign supply_valid = snp_r.supply;
    assign supply_idx   = snp_idx;
    assign wb_valid     = accept && lr.wb;
    assign wb_idx       = lcl_idx;
    assign look_state   = look_st;

    // R11: no bus request and no completion of a new request while waiting
    a_r11_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        !lcl_ready |-> (bus_cmd == BUS_NONE && !wb_valid && (!lcl_done || fill_valid)));

    // R2: a miss request drops ready in the following cycle
    a_r2_miss_waits: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == BUS_RD || bus_cmd == BUS_RDX) |=> !lcl_ready);

    // R4: an upgrade completes in the cycle it is issued
    a_r4_upgrade_done: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == BUS_UPGR) |-> lcl_done);

    // R9: writeback only accompanies an eviction
    a_r9_wb_on_evict: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (lcl_valid && lcl_op == OP_EVICT && lcl_done));

    // R7: supply only answers an active snoop
    a_r7_supply_on_snoop: assert property (@(posedge clk) disable iff (rst)
        supply_valid |-> (snp_cmd != BUS_NONE));

    // R8: after a supply on an ownership snoop, the line is invalid
    a_r8_supply_invalidates: assert property (@(posedge clk) disable iff (rst)
        (supply_valid && snp_cmd != BUS_RD && !(lcl_valid && lcl_ready && lcl_idx == snp_idx))
        |=> (u_array.line_st[$past(snp_idx)] == ST_I));

endmodule

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;

    localparam int LINES = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          lcl_valid;
    logic [1:0]    lcl_op;
    logic [IW-1:0] lcl_idx;
    logic          lcl_ready, lcl_done;
    logic [1:0]    snp_cmd;
    logic [IW-1:0] snp_idx;
    logic          fill_valid, fill_shared;
    logic [1:0]    bus_cmd;
    logic [IW-1:0] bus_idx;
    logic          supply_valid;
    logic [IW-1:0] supply_idx;
    logic          wb_valid;
    logic [IW-1:0] wb_idx;
    logic [IW-1:0] look_idx;
    logic [1:0]    look_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // sampled outputs of the last driven cycle
    int g_bus, g_bidx, g_done, g_sup, g_sidx, g_wb, g_widx, g_ready;

    always #4 clk = ~clk;

    mesi_line_ctrl #(.LINES(LINES)) u_mesi_line_ctrl (
        .clk(clk), .rst(rst),
        .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_idx(lcl_idx),
        .lcl_ready(lcl_ready), .lcl_done(lcl_done),
        .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .fill_valid(fill_valid), .fill_shared(fill_shared),
        .bus_cmd(bus_cmd), .bus_idx(bus_idx),
        .supply_valid(supply_valid), .supply_idx(supply_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .look_idx(look_idx), .look_state(look_state)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lcl_valid   = 1'b0;
        lcl_op      = 2'd3;
        lcl_idx     = '0;
        snp_cmd     = 2'd0;
        snp_idx     = '0;
        fill_valid  = 1'b0;
        fill_shared = 1'b0;
    endtask

    // Called just after a falling edge: drive, sample, pass one rising edge.
    task automatic drive(int lv, int op, int li, int sc, int si, int fv, int fs);
        lcl_valid   = lv[0];
        lcl_op      = 2'(op);
        lcl_idx     = IW'(li);
        snp_cmd     = 2'(sc);
        snp_idx     = IW'(si);
        fill_valid  = fv[0];
        fill_shared = fs[0];
        #1;
        g_bus   = int'(bus_cmd);
        g_bidx  = int'(bus_idx);
        g_done  = int'(lcl_done);
        g_sup   = int'(supply_valid);
        g_sidx  = int'(supply_idx);
        g_wb    = int'(wb_valid);
        g_widx  = int'(wb_idx);
        g_ready = int'(lcl_ready);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic peek(int idx, output int st);
        look_idx = IW'(idx);
        #1;
        st = int'(look_state);
    endtask

    // Bring one line to a given state (0 I, 1 S, 2 E, 3 M) through normal requests.
    task automatic setup(int idx, int st);
        drive(1, 2, idx, 0, 0, 0, 0);
        case (st)
            1: begin drive(1, 0, idx, 0, 0, 0, 0); drive(0, 0, 0, 0, 0, 1, 1); end
            2: begin drive(1, 0, idx, 0, 0, 0, 0); drive(0, 0, 0, 0, 0, 1, 0); end
            3: begin drive(1, 1, idx, 0, 0, 0, 0); drive(0, 0, 0, 0, 0, 1, 0); end
            default: ;
        endcase
    endtask

    // Independent expectation of a snoop (state in, command in).
    function automatic int snp_next(int s, int c);
        if (c == 1) return (s == 3 || s == 2) ? 1 : s;
        if (c == 2 || c == 3) return 0;
        return s;
    endfunction

    function automatic int snp_sup(int s, int c);
        return (c != 0 && s == 3) ? 1 : 0;
    endfunction

    // Expected local outcome: bus command, done, writeback, immediate next state.
    task automatic lcl_expect(int s, int op, output int bus, output int done,
                              output int wb, output int nxt);
        bus = 0; done = 0; wb = 0; nxt = s;
        case (op)
            0: if (s == 0) bus = 1; else done = 1;
            1: begin
                if (s == 0) bus = 2;
                else begin
                    done = 1; nxt = 3;
                    if (s == 1) bus = 3;
                end
            end
            2: begin done = 1; nxt = 0; wb = (s == 3) ? 1 : 0; end
            default: ;
        endcase
    endtask

    function automatic string rq_local(int s, int op);
        if (op == 3) return "R12";
        if (op == 2) return "R9";
        if (s == 0) return (op == 0) ? "R2" : "R3";
        if (op == 1 && s == 1) return "R4";
        if (op == 1 && s == 2) return "R5";
        return "R6";
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int st, eb, ed, ew, en, s1;
        idle_inputs();
        look_idx = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: all lines invalid after reset, ready high
        for (int i = 0; i < LINES; i++) begin
            peek(i, st);
            check("R1", "reset state", st, 0);
        end
        #1;
        check("R1", "ready after reset", int'(lcl_ready), 1);

        // Local op sweep over every start state: R2 R3 R4 R5 R6 R9 R12
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 4; op++) begin
                int idx = (s * 4 + op) % LINES;
                setup(idx, s);
                lcl_expect(s, op, eb, ed, ew, en);
                drive(1, op, idx, 0, 0, 0, 0);
                check(rq_local(s, op), "bus cmd", g_bus, eb);
                if (eb != 0) check(rq_local(s, op), "bus idx", g_bidx, idx);
                check(rq_local(s, op), "done", g_done, ed);
                check(rq_local(s, op), "writeback", g_wb, ew);
                if (ew != 0) check("R9", "wb idx", g_widx, idx);
                peek(idx, st);
                check(rq_local(s, op), "state", st, en);
                if (eb == 1 || eb == 2) begin
                    // R11: outstanding miss holds off a request to another line
                    int other = (idx + 1) % LINES;
                    int ost;
                    setup_probe: begin
                        peek(other, ost);
                    end
                    check("R11", "ready low", int'(lcl_ready), 0);
                    drive(1, 2, other, 0, 0, 0, 0);
                    check("R11", "held bus", g_bus, 0);
                    check("R11", "held done", g_done, 0);
                    check("R11", "held wb", g_wb, 0);
                    peek(other, st);
                    check("R11", "held line", st, ost);
                    drive(0, 0, 0, 0, 0, 1, 1);
                    check(rq_local(s, op), "fill done", g_done, 1);
                    peek(idx, st);
                    check(rq_local(s, op), "fill state", st, (eb == 2) ? 3 : 1);
                    #1;
                    check("R11", "ready after fill", int'(lcl_ready), 1);
                end
            end
        end

        // R2: unshared read fill gives Exclusive
        setup(5, 0);
        drive(1, 0, 5, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        peek(5, st);
        check("R2", "unshared fill", st, 2);

        // Snoop sweep: R7 R8
        for (int s = 0; s < 4; s++) begin
            for (int c = 1; c < 4; c++) begin
                int idx = (s + c) % LINES;
                string rq = (c == 1) ? "R7" : "R8";
                setup(idx, s);
                drive(0, 0, 0, c, idx, 0, 0);
                check(rq, "supply", g_sup, snp_sup(s, c));
                if (g_sup != 0) check(rq, "supply idx", g_sidx, idx);
                peek(idx, st);
                check(rq, "snooped state", st, snp_next(s, c));
            end
        end

        // Same-line collision: R10
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 2; op++) begin
                for (int c = 1; c < 4; c++) begin
                    int idx = (s * 3 + op + c) % LINES;
                    setup(idx, s);
                    s1 = snp_next(s, c);
                    lcl_expect(s1, op, eb, ed, ew, en);
                    drive(1, op, idx, c, idx, 0, 0);
                    check("R10", "collide supply", g_sup, snp_sup(s, c));
                    check("R10", "collide bus", g_bus, eb);
                    check("R10", "collide done", g_done, ed);
                    peek(idx, st);
                    check("R10", "collide state", st, en);
                    if (eb == 1 || eb == 2) drive(0, 0, 0, 0, 0, 1, 1);
                end
            end
        end

        // R7: snoop on one line leaves a same-cycle local hit elsewhere intact
        setup(1, 3);
        setup(2, 2);
        drive(1, 0, 2, 1, 1, 0, 0);
        check("R7", "other-line hit done", g_done, 1);
        check("R7", "other-line supply", g_sup, 1);
        peek(2, st);
        check("R7", "other line kept", st, 2);
        peek(1, st);
        check("R7", "snooped line", st, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule